// File: doc/BRIEF.md
# Multiplexed Shared-Bus Resolver

This block stands in for an on-chip bus that several sources would otherwise drive through tri-state buffers. Each of N sources presents a W-bit data word and an enable bit. The block folds them into one resolved bus word using only AND-OR gating and a final three-way choice, so no high-impedance value ever appears inside the chip.

The resolution is defined for every enable pattern. A lone enabled source passes its word straight through. A bus that nobody drives reads as all ones. A bus that two or more sources drive at once reads as all zeros. Two flags report the idle and clash conditions to the surrounding logic. The block is purely combinational, with no clock and no reset. Its outputs follow its inputs within the same evaluation step.

Top module: `tsb_resolver`

## Requirements
- R1: When exactly one bit of `drv_oe_i` is set, `bus_o` equals the W-bit slice `drv_data_i[i*W +: W]` of that source i (source i occupies bits i*W up to i*W+W-1).
- R2: When no bit of `drv_oe_i` is set, every bit of `bus_o` is 1.
- R3: When two or more bits of `drv_oe_i` are set, every bit of `bus_o` is 0, whatever the data words hold.
- R4: `contend_o` is 1 exactly when two or more enables are set, and 0 otherwise.
- R5: `idle_o` is 1 exactly when no enable is set, and 0 otherwise.
- R6: `idle_o` and `contend_o` are never 1 together. For fully known inputs, `bus_o` never carries an X or Z bit.
- R7: All outputs are combinational and settle in the same time step as an input change, with zero clock cycles of latency.
- R8: The data words of sources whose enable is 0 have no effect on `bus_o` or on either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_data_i | input | N*W | Concatenated source data words; source i in bits i*W +: W |
| drv_oe_i | input | N | Per-source drive enable, bit i for source i |
| bus_o | output | W | Resolved bus word |
| contend_o | output | 1 | High when two or more sources are enabled |
| idle_o | output | 1 | High when no source is enabled |

## Verification
Every result of this block is due zero cycles after a stimulus, because no register lies between any input and any output. The bench changes inputs on the falling clock edge and samples one nanosecond later, in the same clock phase, so that no edge ordering enters the result. Every one of the sixteen enable patterns for four sources is applied with several random data sets. Directed steps then alter only the data of disabled sources and compare the outputs against the values sampled just before the change.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    // How the shared bus resolves for a given enable pattern
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_SOLE  = 2'd1,
        MODE_CLASH = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic idle;
        logic contend;
    } tsb_flags_t;

endpackage

// File: rtl/tsb_enable_classify.sv
module tsb_enable_classify #(
    parameter int N = 4
) (
    input  logic [N-1:0]        oe_i,
    output tsb_pkg::tsb_flags_t flags_o
);

    logic seen_d;
    logic dup_d;

    // Walk the enables once: a set bit after an earlier set bit means a clash
    always_comb begin
        seen_d = 1'b0;
        dup_d  = 1'b0;
        for (int i = 0; i < N; i++) begin
            dup_d  = dup_d | (seen_d & oe_i[i]);
            seen_d = seen_d | oe_i[i];
        end
    end

    assign flags_o.idle    = ~seen_d;
    assign flags_o.contend = dup_d;

endmodule

// File: rtl/tsb_andor_select.sv
module tsb_andor_select #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data_i,
    input  logic [N-1:0]   oe_i,
    output logic [W-1:0]   merged_o
);

    logic [W-1:0] masked_d [N];
    logic [W-1:0] merged_d;

    // Gate each source word with its own enable
    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_mask
            assign masked_d[gi] = data_i[gi*W +: W] & {W{oe_i[gi]}};
        end
    endgenerate

    always_comb begin
        merged_d = '0;
        for (int i = 0; i < N; i++) begin
            merged_d = merged_d | masked_d[i];
        end
    end

    assign merged_o = merged_d;

endmodule

// File: rtl/tsb_resolver.sv
module tsb_resolver #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] drv_data_i,
    input  logic [N-1:0]   drv_oe_i,
    output logic [W-1:0]   bus_o,
    output logic           contend_o,
    output logic           idle_o
);

    import tsb_pkg::*;

    localparam logic [W-1:0] BUS_HIGH = {W{1'b1}};
    localparam logic [W-1:0] BUS_LOW  = {W{1'b0}};

    tsb_flags_t   flags_d;
    logic [W-1:0] merged_d;
    bus_mode_e    mode_d;
    logic [W-1:0] bus_d;

    tsb_enable_classify #(
        .N (N)
    ) u_classify (
        .oe_i    (drv_oe_i),
        .flags_o (flags_d)
    );

    tsb_andor_select #(
        .N (N),
        .W (W)
    ) u_select (
        .data_i   (drv_data_i),
        .oe_i     (drv_oe_i),
        .merged_o (merged_d)
    );

    always_comb begin
        if (flags_d.idle) begin
            mode_d = MODE_IDLE;
        end else if (flags_d.contend) begin
            mode_d = MODE_CLASH;
        end else begin
            mode_d = MODE_SOLE;
        end

        case (mode_d)
            MODE_IDLE:  bus_d = BUS_HIGH;
            MODE_CLASH: bus_d = BUS_LOW;
            default:    bus_d = merged_d;
        endcase
    end

    assign bus_o     = bus_d;
    assign contend_o = flags_d.contend;
    assign idle_o    = flags_d.idle;

endmodule

// File: rtl/tsb_resolver_chk.sv
module tsb_resolver_chk #(
    parameter int N = 4,
    parameter int W = 8
) (
    input logic [N*W-1:0] drv_data_i,
    input logic [N-1:0]   drv_oe_i,
    input logic [W-1:0]   bus_o,
    input logic           contend_o,
    input logic           idle_o
);

    always_comb begin
        if (!$isunknown({drv_oe_i, drv_data_i})) begin
            for (int i = 0; i < N; i++) begin
                if (drv_oe_i == (N'(1) << i)) begin
                    p_sole_passes_r1: assert (bus_o == drv_data_i[i*W +: W])
                        else $error("R1 sole source word not on bus");
                end
            end
            if (drv_oe_i == '0) begin
                p_idle_high_r2: assert (bus_o == {W{1'b1}})
                    else $error("R2 idle bus not all ones");
            end
            if ($countones(drv_oe_i) > 1) begin
                p_clash_low_r3: assert (bus_o == '0)
                    else $error("R3 clashing bus not all zeros");
            end
            p_contend_flag_r4: assert (contend_o == ($countones(drv_oe_i) > 1))
                else $error("R4 contention flag wrong");
            p_idle_flag_r5: assert (idle_o == (drv_oe_i == '0))
                else $error("R5 idle flag wrong");
            p_flags_excl_r6: assert (!(idle_o && contend_o) && !$isunknown(bus_o))
                else $error("R6 flags overlap or bus unknown");
        end
    end

endmodule

bind tsb_resolver tsb_resolver_chk #(
    .N (N),
    .W (W)
) u_chk (
    .drv_data_i (drv_data_i),
    .drv_oe_i   (drv_oe_i),
    .bus_o      (bus_o),
    .contend_o  (contend_o),
    .idle_o     (idle_o)
);

// File: tb/test_tsb_resolver.sv
`timescale 1ns/1ps
module test_tsb_resolver;

    localparam int N = 4;
    localparam int W = 8;
    localparam int WATCHDOG = 20000;

    // {enable pattern, expected idle, expected contend}
    localparam logic [5:0] VEC [16] = '{
        6'b0000_1_0, 6'b0001_0_0, 6'b0010_0_0, 6'b0011_0_1,
        6'b0100_0_0, 6'b0101_0_1, 6'b0110_0_1, 6'b0111_0_1,
        6'b1000_0_0, 6'b1001_0_1, 6'b1010_0_1, 6'b1011_0_1,
        6'b1100_0_1, 6'b1101_0_1, 6'b1110_0_1, 6'b1111_0_1
    };

    logic           clk;
    logic [N*W-1:0] drv_data_i;
    logic [N-1:0]   drv_oe_i;
    logic [W-1:0]   bus_o;
    logic           contend_o;
    logic           idle_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    tsb_resolver #(.N(N), .W(W)) i_tsb_resolver (
        .drv_data_i (drv_data_i),
        .drv_oe_i   (drv_oe_i),
        .bus_o      (bus_o),
        .contend_o  (contend_o),
        .idle_o     (idle_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [W-1:0] ref_bus(input logic [N-1:0] oe,
                                             input logic [N*W-1:0] dat);
        int cnt;
        int idx;
        cnt = 0;
        idx = 0;
        for (int i = 0; i < N; i++) begin
            if (oe[i]) begin
                cnt++;
                idx = i;
            end
        end
        if (cnt == 0) return {W{1'b1}};
        if (cnt > 1)  return '0;
        return dat[idx*W +: W];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] oe, input logic [N*W-1:0] dat);
        @(negedge clk);
        drv_oe_i   = oe;
        drv_data_i = dat;
        #1;  // R7: outputs due in the same step, no clock edge passes
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] dat;
        logic [W-1:0]   bus_before;
        drv_oe_i   = '0;
        drv_data_i = '0;

        // Quiescent state: nothing enabled
        apply('0, '0);
        check("R2 quiescent bus", bus_o, 8'hFF);
        check("R5 quiescent idle", {7'd0, idle_o}, 8'd1);
        check("R4 quiescent contend", {7'd0, contend_o}, 8'd0);

        // Exhaustive enable sweep with random data
        for (int v = 0; v < 16; v++) begin
            for (int rep = 0; rep < 4; rep++) begin
                dat = {$urandom, $urandom};
                apply(VEC[v][5:2], dat);
                if (VEC[v][1])
                    check("R2 idle sweep bus", bus_o, ref_bus(VEC[v][5:2], dat));
                else if (VEC[v][0])
                    check("R3 clash sweep bus", bus_o, ref_bus(VEC[v][5:2], dat));
                else
                    check("R1 sole sweep bus", bus_o, ref_bus(VEC[v][5:2], dat));
                check("R5 sweep idle", {7'd0, idle_o}, {7'd0, VEC[v][1]});
                check("R4 sweep contend", {7'd0, contend_o}, {7'd0, VEC[v][0]});
                check("R6 flags exclusive", {7'd0, idle_o & contend_o}, 8'd0);
            end
        end

        // R3 with every source driving all ones still gives zeros
        apply(4'b1001, {N*W{1'b1}});
        check("R3 clash all-ones data", bus_o, 8'h00);

        // R1 corner: sole source word of all zeros, and of all ones
        apply(4'b0100, 32'hFFFF_FFFF & ~32'h00FF_0000);
        check("R1 sole zero word", bus_o, 8'h00);
        apply(4'b0001, 32'h0000_00FF);
        check("R1 sole ones word", bus_o, 8'hFF);

        // R8: disturb only disabled sources
        apply(4'b0010, 32'h1234_A55A);
        bus_before = bus_o;
        check("R1 sole before disturb", bus_o, 8'hA5);
        apply(4'b0010, 32'hEDCB_A5A5);
        check("R8 disabled data ignored bus", bus_o, bus_before);
        check("R8 disabled data ignored idle", {7'd0, idle_o}, 8'd0);
        check("R8 disabled data ignored contend", {7'd0, contend_o}, 8'd0);
        apply(4'b0000, 32'h0000_0000);
        apply(4'b0000, 32'h5A5A_5A5A);
        check("R8 idle ignores data", bus_o, 8'hFF);

        // R6: known inputs never produce unknown bus bits
        apply(4'b0110, 32'h0F0F_0F0F);
        checks++;
        if ($isunknown(bus_o)) begin
            failures++;
            $display("FAIL R6 unknown bus actual=%b expected=known", bus_o);
        end

        // R7: change and sample inside one low phase, no edge in between
        @(negedge clk);
        drv_oe_i   = 4'b1000;
        drv_data_i = 32'h3C00_0000;
        #1;
        check("R7 same-step response", bus_o, 8'h3C);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule